// File: doc/BRIEF.md
# Prioritized Voice Interrupt Status Reader

This block keeps two pending-flag vectors, one bit per voice. One vector records wavetable end-of-loop events and the other records volume-ramp end events. The voice engines raise flags with single-cycle set pulses, and any number of voices may pulse in the same cycle. A host read of the voice-interrupt status register services exactly one voice. That voice is the lowest-numbered one pending, and the block returns its number with a cause tag in the upper bits. The block then clears that voice's pending flag and emits a one-cycle clear strobe. The register file that sits outside the block uses that strobe to drop bit 7 of the matching per-voice control register.

The block also maintains a shared interrupt status byte. Bit 5 reports that wavetable flags are pending and bit 6 reports that ramp flags are pending. The remaining bits carry level-sensitive causes from elsewhere in the chip. A level interrupt request follows the byte: it stays high while any bit is set. A global clear empties both vectors and the status byte at once.

Top module: `voice_irq_reader`

## Requirements
- R1: After `rst_n` low, `rdData` reads 0xE8, both clear strobes and `irqReq` are low, and `irqStatus` is 0x00.
- R2: A read services the lowest-numbered pending voice among voices 0 to 30. Voice 31 is never reported or cleared by a read.
- R3: Wavetable flags take priority. Ramp flags are examined only when the whole wavetable vector is empty, voice 31 included. If the wavetable vector holds only voice 31, the read returns 0xE8 and no ramp voice is serviced.
- R4: The read code is 0x60 OR the voice number for a wavetable service, and 0x80 OR the voice number for a ramp service. The code is 0xE8 when no voice is serviced.
- R5: `rdData` and the pending-flag clear take effect on the clock edge that samples `rdStb`. `rdData` holds its value when `rdStb` is low.
- R6: A wavetable service raises `waveBitClr` for exactly one cycle after the read edge, and a ramp service raises `rampBitClr` the same way. `clrVoice` gives the serviced voice. The two strobes are never high together, and neither rises on a read that returns 0xE8.
- R7: `irqStatus` bit 5 is high exactly when the wavetable vector is non-empty, and bit 6 is high exactly when the ramp vector is non-empty. Each bit is set by a set pulse and cleared by the service that empties its vector.
- R8: `irqStatus` bits 0 to 4 and bit 7 are `extPending` registered by one cycle. Bits 5 and 6 of `extPending` are ignored.
- R9: `irqReq` is the OR of all `irqStatus` bits, delayed by one cycle.
- R10: A set pulse and a read service for the same voice in the same cycle leave that voice pending. The read still returns that voice.
- R11: `globalClr` empties both vectors and sets `irqStatus` to 0x00 on the next edge. It takes priority over set pulses in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| globalClr | input | 1 | Synchronous clear of the flags and the status byte |
| waveSet | input | 32 | Per-voice wavetable event pulses |
| rampSet | input | 32 | Per-voice volume-ramp event pulses |
| extPending | input | 8 | Level causes from other sources (bits 5 and 6 ignored) |
| rdStb | input | 1 | Host read strobe for the voice status register |
| rdData | output | 8 | Registered read code |
| waveBitClr | output | 1 | One-cycle strobe: clear bit 7 of the voice's wave-control register |
| rampBitClr | output | 1 | One-cycle strobe: clear bit 7 of the voice's ramp-control register |
| clrVoice | output | 5 | Voice addressed by the clear strobe |
| irqStatus | output | 8 | Shared interrupt status byte |
| irqReq | output | 1 | Level interrupt request |

## Verification
The assertions assume that `globalClr` never arrives in the same cycle as a read strobe. They also assume that set pulses last a single cycle. Under those conditions, the status bits track vector emptiness exactly, and a serviced bit stays set only when the same voice's set pulse arrives in that cycle. The stimulus drives every input on the falling edge and holds each pulse for one cycle. It issues global clears only between read sequences. It hits the same-cycle set-and-service case on purpose, with a read and a set pulse for the serviced voice in the same cycle.

// File: rtl/voice_irq_pkg.sv
package voice_irq_pkg;
  localparam int VOICE_W    = 5;
  localparam int NUM_VOICES = 1 << VOICE_W;
  localparam int SCAN_COUNT = NUM_VOICES - 1;
  localparam int NUM_CAUSES = 2;
  localparam int CAUSE_WAVE = 0;
  localparam int CAUSE_RAMP = 1;

  localparam logic [7:0] WAVE_TAG  = 8'h60;
  localparam logic [7:0] RAMP_TAG  = 8'h80;
  localparam logic [7:0] IDLE_CODE = 8'hE8;

  localparam int WAVE_STAT_BIT = 5;
  localparam int RAMP_STAT_BIT = 6;
  localparam logic [7:0] OWN_STAT_MASK = (8'h01 << WAVE_STAT_BIT) | (8'h01 << RAMP_STAT_BIT);

  typedef struct packed {
    logic               svcWave;
    logic               svcRamp;
    logic [VOICE_W-1:0] voice;
  } svcStrobe_t;
endpackage

// File: rtl/vir_prio_enc.sv
module vir_prio_enc #(
  parameter int WIDTH = 32,
  parameter int SCAN  = 31,
  parameter int IDX_W = 5
) (
  input  logic [WIDTH-1:0] pendVec,
  output logic             anyPend,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  assign anyPend = |pendVec;

  // Downward walk: the last assignment made belongs to the lowest set bit.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = SCAN - 1; i >= 0; i--) begin
      if (pendVec[i]) begin
        hit = 1'b1;
        idx = i[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/vir_ctrl.sv
module vir_ctrl
  import voice_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rdStb,
  input  logic [NUM_VOICES-1:0] waveVec,
  input  logic [NUM_VOICES-1:0] rampVec,
  output svcStrobe_t            svc,
  output logic [7:0]            rdData,
  output logic                  waveBitClr,
  output logic                  rampBitClr,
  output logic [VOICE_W-1:0]    clrVoice
);
  localparam int PAD_W = 8 - VOICE_W;

  logic [NUM_CAUSES-1:0][NUM_VOICES-1:0] causeVec;
  logic [NUM_CAUSES-1:0]                 causeAny;
  logic [NUM_CAUSES-1:0]                 causeHit;
  logic [NUM_CAUSES-1:0][VOICE_W-1:0]    causeIdx;
  logic [7:0]                            nextCode;

  assign causeVec[CAUSE_WAVE] = waveVec;
  assign causeVec[CAUSE_RAMP] = rampVec;

  for (genvar c = 0; c < NUM_CAUSES; c++) begin : g_enc
    vir_prio_enc #(
      .WIDTH(NUM_VOICES),
      .SCAN (SCAN_COUNT),
      .IDX_W(VOICE_W)
    ) u_enc (
      .pendVec(causeVec[c]),
      .anyPend(causeAny[c]),
      .hit    (causeHit[c]),
      .idx    (causeIdx[c])
    );
  end

  always_comb begin
    svc      = '0;
    nextCode = IDLE_CODE;
    if (rdStb) begin
      if (causeAny[CAUSE_WAVE]) begin
        if (causeHit[CAUSE_WAVE]) begin
          svc.svcWave = 1'b1;
          svc.voice   = causeIdx[CAUSE_WAVE];
          nextCode    = WAVE_TAG | {{PAD_W{1'b0}}, causeIdx[CAUSE_WAVE]};
        end
      end else if (causeAny[CAUSE_RAMP] && causeHit[CAUSE_RAMP]) begin
        svc.svcRamp = 1'b1;
        svc.voice   = causeIdx[CAUSE_RAMP];
        nextCode    = RAMP_TAG | {{PAD_W{1'b0}}, causeIdx[CAUSE_RAMP]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData     <= IDLE_CODE;
      waveBitClr <= 1'b0;
      rampBitClr <= 1'b0;
      clrVoice   <= '0;
    end else begin
      waveBitClr <= svc.svcWave;
      rampBitClr <= svc.svcRamp;
      if (rdStb) begin
        rdData <= nextCode;
      end
      if (svc.svcWave || svc.svcRamp) begin
        clrVoice <= svc.voice;
      end
    end
  end

  // R6
  one_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({waveBitClr, rampBitClr}));

  // R3
  ramp_behind_wave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rampBitClr |-> $past(waveVec == '0));

  // R2
  scan_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waveBitClr || rampBitClr) |-> (clrVoice < VOICE_W'(SCAN_COUNT)));

  // R5
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdStb |=> $stable(rdData));
endmodule

// File: rtl/vir_datapath.sv
module vir_datapath
  import voice_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  globalClr,
  input  logic [NUM_VOICES-1:0] waveSet,
  input  logic [NUM_VOICES-1:0] rampSet,
  input  logic [7:0]            extPending,
  input  svcStrobe_t            svc,
  output logic [NUM_VOICES-1:0] waveVec,
  output logic [NUM_VOICES-1:0] rampVec,
  output logic [7:0]            irqStatus,
  output logic                  irqReq
);
  logic [NUM_CAUSES-1:0][NUM_VOICES-1:0] setVec;
  logic [NUM_CAUSES-1:0][NUM_VOICES-1:0] pendQ;
  logic [NUM_CAUSES-1:0][NUM_VOICES-1:0] pendNext;
  logic [NUM_CAUSES-1:0]                 svcHit;
  logic [NUM_CAUSES-1:0]                 statQ;
  logic [NUM_CAUSES-1:0]                 statNext;
  logic [7:0]                            extQ;

  assign setVec[CAUSE_WAVE] = waveSet;
  assign setVec[CAUSE_RAMP] = rampSet;
  assign svcHit[CAUSE_WAVE] = svc.svcWave;
  assign svcHit[CAUSE_RAMP] = svc.svcRamp;

  // Service clear first, then the set pulse, so a new event for the
  // serviced voice in the same cycle survives.
  always_comb begin
    for (int c = 0; c < NUM_CAUSES; c++) begin
      pendNext[c] = pendQ[c];
      if (svcHit[c]) begin
        pendNext[c][svc.voice] = 1'b0;
      end
      pendNext[c] = pendNext[c] | setVec[c];

      statNext[c] = statQ[c];
      if (|setVec[c]) begin
        statNext[c] = 1'b1;
      end else if (svcHit[c] && (pendNext[c] == '0)) begin
        statNext[c] = 1'b0;
      end

      if (globalClr) begin
        pendNext[c] = '0;
        statNext[c] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendQ  <= '0;
      statQ  <= '0;
      extQ   <= '0;
      irqReq <= 1'b0;
    end else begin
      pendQ  <= pendNext;
      statQ  <= statNext;
      extQ   <= globalClr ? 8'h00 : (extPending & ~OWN_STAT_MASK);
      irqReq <= |irqStatus;
    end
  end

  always_comb begin
    irqStatus                = extQ;
    irqStatus[WAVE_STAT_BIT] = statQ[CAUSE_WAVE];
    irqStatus[RAMP_STAT_BIT] = statQ[CAUSE_RAMP];
  end

  assign waveVec = pendQ[CAUSE_WAVE];
  assign rampVec = pendQ[CAUSE_RAMP];

  // R7
  wave_stat_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqStatus[WAVE_STAT_BIT] == (waveVec != '0));

  // R7
  ramp_stat_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqStatus[RAMP_STAT_BIT] == (rampVec != '0));

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irqReq == $past(|irqStatus)));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc.svcWave && !globalClr) |=> (waveVec[$past(svc.voice)] == $past(waveSet[svc.voice])));

  // R11
  global_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    globalClr |=> ((waveVec == '0) && (rampVec == '0) && (irqStatus == 8'h00)));
endmodule

// File: rtl/voice_irq_reader.sv
module voice_irq_reader
  import voice_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  globalClr,
  input  logic [NUM_VOICES-1:0] waveSet,
  input  logic [NUM_VOICES-1:0] rampSet,
  input  logic [7:0]            extPending,
  input  logic                  rdStb,
  output logic [7:0]            rdData,
  output logic                  waveBitClr,
  output logic                  rampBitClr,
  output logic [VOICE_W-1:0]    clrVoice,
  output logic [7:0]            irqStatus,
  output logic                  irqReq
);
  svcStrobe_t            svc;
  logic [NUM_VOICES-1:0] waveVec;
  logic [NUM_VOICES-1:0] rampVec;

  vir_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rdStb     (rdStb),
    .waveVec   (waveVec),
    .rampVec   (rampVec),
    .svc       (svc),
    .rdData    (rdData),
    .waveBitClr(waveBitClr),
    .rampBitClr(rampBitClr),
    .clrVoice  (clrVoice)
  );

  vir_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .globalClr (globalClr),
    .waveSet   (waveSet),
    .rampSet   (rampSet),
    .extPending(extPending),
    .svc       (svc),
    .waveVec   (waveVec),
    .rampVec   (rampVec),
    .irqStatus (irqStatus),
    .irqReq    (irqReq)
  );
endmodule

// File: tb/tb_voice_irq_reader.sv
module tb_voice_irq_reader;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        globalClr = 1'b0;
  logic [31:0] waveSet = '0;
  logic [31:0] rampSet = '0;
  logic [7:0]  extPending = '0;
  logic        rdStb = 1'b0;
  logic [7:0]  rdData;
  logic        waveBitClr, rampBitClr;
  logic [4:0]  clrVoice;
  logic [7:0]  irqStatus;
  logic        irqReq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] mWave = '0;
  logic [31:0] mRamp = '0;
  logic [7:0]  mExt = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  voice_irq_reader dut (
    .clk(clk), .rst_n(rst_n), .globalClr(globalClr), .waveSet(waveSet),
    .rampSet(rampSet), .extPending(extPending), .rdStb(rdStb), .rdData(rdData),
    .waveBitClr(waveBitClr), .rampBitClr(rampBitClr), .clrVoice(clrVoice),
    .irqStatus(irqStatus), .irqReq(irqReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expStat();
    logic [7:0] s;
    s = mExt & 8'h9F;
    s[5] = |mWave;
    s[6] = |mRamp;
    return s;
  endfunction

  task automatic applySet(input logic [31:0] w, input logic [31:0] r);
    @(negedge clk);
    waveSet = w;
    rampSet = r;
    @(negedge clk);
    waveSet = '0;
    rampSet = '0;
    mWave |= w;
    mRamp |= r;
  endtask

  task automatic doGlobalClr();
    @(negedge clk);
    globalClr = 1'b1;
    @(negedge clk);
    globalClr = 1'b0;
    mWave = '0;
    mRamp = '0;
    chk("R11 status after clear", irqStatus, 8'h00);
  endtask

  task automatic doRead(input string req);
    logic [7:0] expCode;
    logic       expW, expR;
    logic [4:0] expV;
    bit         found;
    expCode = 8'hE8; expW = 0; expR = 0; expV = 0; found = 0;
    if (mWave != 0) begin
      for (int v = 0; v < 31; v++)
        if (!found && mWave[v]) begin
          found = 1; expCode = 8'h60 | 8'(v); expW = 1; expV = 5'(v);
        end
      if (found) mWave[expV] = 1'b0;
    end else if (mRamp != 0) begin
      for (int v = 0; v < 31; v++)
        if (!found && mRamp[v]) begin
          found = 1; expCode = 8'h80 | 8'(v); expR = 1; expV = 5'(v);
        end
      if (found) mRamp[expV] = 1'b0;
    end
    @(negedge clk);
    rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0;
    chk({req, " R4 code"}, rdData, expCode);
    chk({req, " R6 waveBitClr"}, waveBitClr, expW);
    chk({req, " R6 rampBitClr"}, rampBitClr, expR);
    if (expW || expR) chk({req, " R6 clrVoice"}, clrVoice, expV);
    chk({req, " R7 status"}, irqStatus, expStat());
    @(negedge clk);
    chk({req, " R9 irqReq"}, irqReq, |expStat());
    chk({req, " R6 strobe width"}, {waveBitClr, rampBitClr}, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] patW [4];
    logic [31:0] patR [4];
    patW[0] = 32'h5555_5555; patR[0] = 32'h0F0F_00F0;
    patW[1] = 32'h0000_0000; patR[1] = 32'h7FFF_FFFF;
    patW[2] = 32'h8000_0003; patR[2] = 32'h0000_0100;
    patW[3] = 32'h4000_0001; patR[3] = 32'h8000_0002;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdData", rdData, 8'hE8);
    chk("R1 strobes", {waveBitClr, rampBitClr}, 2'b00);
    chk("R1 irqStatus", irqStatus, 8'h00);
    chk("R1 irqReq", irqReq, 1'b0);
    rst_n = 1'b1;

    doRead("R4 empty");

    // R2 R4 R6 R7: single voice sweep, both causes
    for (int v = 0; v < 31; v++) begin
      applySet(32'h1 << v, '0);
      chk("R7 wave bit set", irqStatus[5], 1'b1);
      doRead("R2 wave sweep");
      applySet('0, 32'h1 << v);
      chk("R7 ramp bit set", irqStatus[6], 1'b1);
      doRead("R2 ramp sweep");
    end

    // R2: voice 31 is never serviced
    applySet('0, 32'h8000_0000);
    doRead("R2 ramp voice31");
    doRead("R2 ramp voice31 again");
    doGlobalClr();
    doRead("R11 empty after clear");

    // R3: wavetable voice 31 alone blocks ramp service
    applySet(32'h8000_0000, 32'h1);
    doRead("R3 blocked ramp");
    chk("R3 ramp still pending", irqStatus[6], 1'b1);
    doGlobalClr();

    // multi-voice patterns, drained in priority order
    for (int p = 0; p < 4; p++) begin
      int n;
      applySet(patW[p], patR[p]);
      n = $countones(patW[p][30:0]) + $countones(patR[p][30:0]) + 1;
      for (int k = 0; k < n; k++) doRead("R3 pattern");
      doGlobalClr();
    end

    // R10: set and service for the same voice in one cycle
    applySet(32'h10, '0);
    @(negedge clk);
    rdStb = 1'b1;
    waveSet = 32'h10;
    @(negedge clk);
    rdStb = 1'b0;
    waveSet = '0;
    chk("R10 code", rdData, 8'h64);
    chk("R10 strobe", waveBitClr, 1'b1);
    chk("R10 still pending", irqStatus[5], 1'b1);
    doRead("R10 reread");

    // R5: rdData holds without a read
    applySet(32'h2, 32'h4);
    repeat (3) @(negedge clk);
    chk("R5 hold", rdData, 8'h64);
    doRead("R5 next");
    doRead("R5 next");

    // R8 R9: external level causes
    @(negedge clk);
    extPending = 8'hFF;
    mExt = 8'hFF;
    @(negedge clk);
    chk("R8 ext bits", irqStatus, 8'h9F);
    @(negedge clk);
    chk("R9 irqReq ext", irqReq, 1'b1);
    extPending = 8'h00;
    mExt = 8'h00;
    @(negedge clk);
    chk("R8 ext cleared", irqStatus, 8'h00);
    @(negedge clk);
    chk("R9 irqReq drop", irqReq, 1'b0);

    // R11: global clear wins over same-cycle set
    @(negedge clk);
    globalClr = 1'b1;
    waveSet = 32'h1;
    @(negedge clk);
    globalClr = 1'b0;
    waveSet = '0;
    chk("R11 clear wins", irqStatus, 8'h00);
    doRead("R11 empty");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule